// File: doc/BRIEF.md
# Skewed Parallel Matrix Store

This block keeps an N-by-N matrix spread over N independent memory banks so that any complete row or any complete column can be read, or written, in a single cycle. Element (r,c), counted from zero, sits in bank (c + r) mod N at local word r. Because each row is shifted one bank further than the row above it, the members of a row and the members of a column always fall in N different banks.

A command carries a valid flag, a write flag, an access kind (row or column) and an index. On an access, every bank forms its own local word address. On reads, a circular rotation network turns the bank outputs back into lane order. On writes, the inverse rotation turns lane data into bank order before it is stored. Read data comes out one cycle after the command, together with a valid flag.

Top module: `skew_matrix_store`

## Requirements
- R1: While reset is asserted, and after it is released until the first read command, rd_valid is 0.
- R2: rd_valid is 1 in the cycle after a command with cmd_valid=1 and cmd_write=0, and 0 in the cycle after any other cycle.
- R3: A read with cmd_kind=0 (row) and cmd_index=r returns element (r,c) on lane c, where lane k occupies rd_data bits [k*DW +: DW].
- R4: A read with cmd_kind=1 (column) and cmd_index=c returns element (r,c) on lane r.
- R5: A write with cmd_kind=0 and cmd_index=r stores lane c of wr_data (bits [c*DW +: DW]) as element (r,c), and this is visible to later column reads.
- R6: A write with cmd_kind=1 and cmd_index=c stores lane r of wr_data as element (r,c), and this is visible to later row reads.
- R7: A read of the same kind and index issued in the cycle right after a write returns exactly the written vector.
- R8: A write command raises no rd_valid and leaves rd_data unchanged.
- R9: rd_data holds its last read value in every cycle that follows a cycle without a read command.
- R10: Indexes 0 and N-1 of both kinds wrap across the banks correctly, so every element of the matrix is reachable by both a row and a column access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_kind | input | 1 | 0 = row access, 1 = column access |
| cmd_index | input | IW = clog2(N) | Row or column number, 0 to N-1 |
| wr_data | input | N*DW | Write vector, lane k at bits [k*DW +: DW] |
| rd_valid | output | 1 | rd_data carries a read result |
| rd_data | output | N*DW | Read vector, lane k at bits [k*DW +: DW] |

## Verification
The bench builds the block with its defaults, N=4 and DW=16. With these values there are only sixteen elements, so the bench can fill the whole matrix and check every element. It reads all four rows and all four columns after row writes, and again after column writes. In this way every rotation amount from 0 to 3 is used in both directions, and so are the wrap from bank N-1 back to bank 0 and a write followed at once by a read.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic {
    ACC_ROW = 1'b0,
    ACC_COL = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/skew_addr_gen.sv
module skew_addr_gen
  import skew_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  acc_kind_e               kind,
  input  logic [IW-1:0]           idx,
  output logic [N-1:0][IW-1:0]    offs
);
  // row r: every bank reads word r; column c: bank m reads word (m - c) mod N
  for (genvar m = 0; m < N; m++) begin : g_off
    always_comb begin
      int t;
      t = m + N - int'(idx);
      if (t >= N) t = t - N;
      if (kind == ACC_COL) offs[m] = IW'(t);
      else                 offs[m] = idx;
    end
  end
endmodule

// File: rtl/skew_rotator.sv
module skew_rotator #(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int IW   = 2,
  parameter bit LEFT = 1'b1
) (
  input  logic [N-1:0][DW-1:0] din,
  input  logic [IW-1:0]        sh,
  output logic [N-1:0][DW-1:0] dout
);
  // LEFT:  dout[k] = din[(k + sh) mod N]
  // right: dout[k] = din[(k - sh) mod N]
  for (genvar k = 0; k < N; k++) begin : g_lane
    logic [IW-1:0] sel;
    always_comb begin
      int s;
      if (LEFT) s = k + int'(sh);
      else      s = k + N - int'(sh);
      if (s >= N) s = s - N;
      sel     = IW'(s);
      dout[k] = din[sel];
    end
  end
endmodule

// File: rtl/skew_bank.sv
module skew_bank #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_d;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_comb begin
    q_d = q;
    if (re) q_d = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/skew_matrix_store.sv
module skew_matrix_store
  import skew_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic            cmd_write,
  input  logic            cmd_kind,
  input  logic [IW-1:0]   cmd_index,
  input  logic [N*DW-1:0] wr_data,
  output logic            rd_valid,
  output logic [N*DW-1:0] rd_data
);
  logic                  rd_cmd, wr_cmd;
  acc_kind_e             kind;
  logic [N-1:0][IW-1:0]  offs;
  logic [N-1:0][DW-1:0]  wr_lanes, wr_banks;
  logic [N-1:0][DW-1:0]  bank_q, rd_lanes;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  valid_d;

  assign rd_cmd   = cmd_valid & ~cmd_write;
  assign wr_cmd   = cmd_valid &  cmd_write;
  assign kind     = acc_kind_e'(cmd_kind);
  assign wr_lanes = wr_data;

  skew_addr_gen #(.N(N), .IW(IW)) u_addr (
    .kind (kind),
    .idx  (cmd_index),
    .offs (offs)
  );

  // lane c goes to bank (c + idx) mod N
  skew_rotator #(.N(N), .DW(DW), .IW(IW), .LEFT(1'b0)) u_wr_rot (
    .din  (wr_lanes),
    .sh   (cmd_index),
    .dout (wr_banks)
  );

  for (genvar m = 0; m < N; m++) begin : g_bank
    skew_bank #(.DEPTH(N), .DW(DW), .AW(IW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_cmd),
      .re    (rd_cmd),
      .addr  (offs[m]),
      .wd    (wr_banks[m]),
      .q     (bank_q[m])
    );
  end

  always_comb begin
    valid_d = rd_cmd;
    idx_d   = idx_q;
    if (rd_cmd) idx_d = cmd_index;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      idx_q    <= '0;
    end else begin
      rd_valid <= valid_d;
      idx_q    <= idx_d;
    end
  end

  // lane k takes bank (k + idx) mod N
  skew_rotator #(.N(N), .DW(DW), .IW(IW), .LEFT(1'b1)) u_rd_rot (
    .din  (bank_q),
    .sh   (idx_q),
    .dout (rd_lanes)
  );

  assign rd_data = rd_lanes;
endmodule

// File: rtl/skew_matrix_store_chk.sv
module skew_matrix_store_chk #(
  parameter int N  = 4,
  parameter int DW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_write,
  input logic            cmd_kind,
  input logic [IW-1:0]   cmd_index,
  input logic [N*DW-1:0] wr_data,
  input logic            rd_valid,
  input logic [N*DW-1:0] rd_data
);
  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (!rd_valid);
  end

  assert_read_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rd_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rd_valid);

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> $stable(rd_data));

  assert_write_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) ##1
    (cmd_valid && !cmd_write && cmd_kind == $past(cmd_kind) && cmd_index == $past(cmd_index))
    |=> rd_data == $past(wr_data, 2));
endmodule

bind skew_matrix_store skew_matrix_store_chk #(.N(N), .DW(DW)) u_chk (.*);

// File: tb/skew_matrix_store_tb.sv
`timescale 1ns/1ps
module skew_matrix_store_tb;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid, cmd_write, cmd_kind;
  logic [IW-1:0]   cmd_index;
  logic [N*DW-1:0] wr_data;
  logic            rd_valid;
  logic [N*DW-1:0] rd_data;

  int total = 0;
  int bad   = 0;

  logic [DW-1:0]   refm [N][N];
  logic [N*DW-1:0] hold_exp;

  bit              qv [$];
  logic [N*DW-1:0] qd [$];
  string           qr [$];

  always #5 clk = ~clk;

  skew_matrix_store #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_kind(cmd_kind), .cmd_index(cmd_index), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [N*DW-1:0] act,
                       input logic [N*DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] val(input int r, input int c, input int gen);
    return DW'(gen * 4096 + r * 16 + c + 1);
  endfunction

  function automatic logic [N*DW-1:0] expect_vec(input bit col, input int idx);
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++)
      v[k*DW +: DW] = col ? refm[k][idx] : refm[idx][k];
    return v;
  endfunction

  task automatic do_write(input bit col, input int idx, input int gen);
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++) begin
      if (col) begin v[k*DW +: DW] = val(k, idx, gen); refm[k][idx] = val(k, idx, gen); end
      else     begin v[k*DW +: DW] = val(idx, k, gen); refm[idx][k] = val(idx, k, gen); end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_kind = col; cmd_index = IW'(idx); wr_data = v;
    qv.push_back(1'b0); qd.push_back(hold_exp); qr.push_back(col ? "R6 R8" : "R5 R8");
  endtask

  task automatic do_read(input bit col, input int idx, input string req);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_kind = col; cmd_index = IW'(idx);
    wr_data = {N*DW{1'b1}};
    hold_exp = expect_vec(col, idx);
    qv.push_back(1'b1); qd.push_back(hold_exp); qr.push_back(req);
  endtask

  task automatic do_idle();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_kind = 1'b0; cmd_index = '0;
    qv.push_back(1'b0); qd.push_back(hold_exp); qr.push_back("R9");
  endtask

  // monitor: pops one expectation per captured command
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (qv.size() > 0) begin
        bit ev; logic [N*DW-1:0] ed; string er;
        ev = qv.pop_front(); ed = qd.pop_front(); er = qr.pop_front();
        check(rd_valid == ev, {"R2 valid ", er}, {{(N*DW-1){1'b0}}, rd_valid},
              {{(N*DW-1){1'b0}}, ev});
        check(rd_data == ed, er, rd_data, ed);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    hold_exp  = '0;
    rst_n     = 1'b0;
    cmd_valid = 1'b0; cmd_write = 1'b0; cmd_kind = 1'b0; cmd_index = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #2;
    check(rd_valid == 1'b0, "R1 in reset", {{(N*DW-1){1'b0}}, rd_valid}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle cycles after release keep rd_valid low
    do_idle(); do_idle();

    // R5: fill through row writes, read back every row and column
    for (int r = 0; r < N; r++) do_write(1'b0, r, 1);
    for (int r = 0; r < N; r++) do_read(1'b0, r, "R3 R10 row read");
    for (int c = 0; c < N; c++) do_read(1'b1, c, "R4 R5 R10 column read after row writes");

    // R6: overwrite through column writes, read rows
    for (int c = N - 1; c >= 0; c--) do_write(1'b1, c, 2);
    for (int r = N - 1; r >= 0; r--) do_read(1'b0, r, "R3 R6 row read after column writes");
    for (int c = 0; c < N; c++) do_read(1'b1, c, "R4 column read");

    // R9: hold over idle cycles
    do_idle(); do_idle(); do_idle();

    // R7: write then read at once, same kind and index
    do_write(1'b0, 2, 3);     do_read(1'b0, 2, "R7 row write then read");
    do_write(1'b1, 3, 4);     do_read(1'b1, 3, "R7 column write then read");
    do_write(1'b1, 0, 5);     do_read(1'b1, 0, "R7 R10 column 0 write then read");
    do_write(1'b0, N - 1, 6); do_read(1'b0, N - 1, "R7 R10 last row write then read");

    // R8: a write between reads leaves rd_data
    do_read(1'b1, 1, "R4 column read");
    do_write(1'b0, 1, 7);
    do_idle();
    for (int c = 0; c < N; c++) do_read(1'b1, c, "R4 R5 column read after mixed writes");
    for (int r = 0; r < N; r++) do_read(1'b0, r, "R3 R6 final row read");
    do_idle(); do_idle();

    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule